// File: doc/BRIEF.md
# Microcode Address Front-End

This block sits at the head of a microcoded execution unit. When the instruction queue raises its first-byte strobe, the opcode byte on the queue bus is captured into an opcode register and the micro-step counter is cleared. On the next clock the opcode is translated into a 9-bit entry address for the microcode ROM. That entry and the current step are registered and presented to the ROM read port together with a valid flag. Fetching a micro-instruction therefore costs one full cycle after the load.

The three-bit operation field of the opcode (bits 5:3) is held in a separate hidden register. The ALU reads it later in the microcode routine. While no new opcode arrives, the step counter advances once per clock, so the ROM receives a new step every cycle while the entry address stays fixed. A new strobe on every clock gives one new routine start per clock.

A hold input freezes both stages.

Top module: `ucode_addr_front`

## Requirements
- R1: Synchronous active-high reset clears the outputs: `rom_valid`=0, `rom_entry`=0, `rom_step`=0, `alu_op`=0. After reset, `rom_valid` stays 0 until the first strobe.
- R2: A strobe at clock edge k with hold low loads the queue byte. After edge k, `alu_op` equals byte bits [5:3].
- R3: After edge k+1 (hold low), `rom_valid`=1, `rom_step`=0 and `rom_entry` is the mapped entry of the loaded byte.
- R4: The entry map works as follows:
  - bits[7:6]=00 with bit2=0 gives 0x018;
  - bits[7:6]=00 with bits[2:1]=10 gives 0x01C;
  - bits[7:4]=0100 gives 0x040;
  - bits[7:4]=0101 gives 0x050;
  - every other opcode gives the trap entry 0x1FF.
- R5: With no strobe and hold low, the step advances by one per clock, and `rom_step` follows it one clock later. `rom_entry` does not change.
- R6: The step saturates at 2^STEP_W-1 (15 by default).
- R7: Strobes on consecutive clocks each start a new routine. `rom_entry` changes on consecutive clocks and `rom_step` is 0 each time.
- R8: While hold is high, every output keeps its value and a strobe is ignored.
- R9: `alu_op` changes only on an accepted strobe, and never as the step advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freezes both stages |
| first_strobe | input | 1 | First opcode byte is valid on the queue bus |
| queue_byte | input | 8 | Opcode byte from the instruction queue |
| rom_entry | output | ENTRY_W (9) | Registered routine entry address for the ROM |
| rom_step | output | STEP_W (4) | Registered micro-step for the ROM |
| rom_valid | output | 1 | ROM address is valid |
| alu_op | output | 3 | Hidden operation field, opcode bits [5:3] |

## Verification
The operation field is due one clock after the strobe edge. The ROM entry, its step and the valid flag are due two clocks after that edge, and each later step appears one clock after the counter moves. Inputs are driven 1 ns after a rising edge, and outputs are sampled at that same point after the edge whose effect is expected. The bench counts edges from the strobe: one edge for `alu_op` and two for the ROM outputs. During hold, the bench confirms that the ROM outputs and the operation field stay where they were. After hold is released, it confirms that the step resumes from where it stopped.

// File: rtl/ucf_pkg.sv
package ucf_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [2:0] {
        CLS_TRAP,
        CLS_ALU_RM,
        CLS_ALU_ACC,
        CLS_INCDEC,
        CLS_STACK
    } op_class_e;

    // Decode the opcode family that selects a microcode routine.
    function automatic op_class_e classify(input logic [OPC_W-1:0] op);
        if (op[7:6] == 2'b00 && op[2] == 1'b0)    return CLS_ALU_RM;
        if (op[7:6] == 2'b00 && op[2:1] == 2'b10) return CLS_ALU_ACC;
        if (op[7:4] == 4'h4)                      return CLS_INCDEC;
        if (op[7:4] == 4'h5)                      return CLS_STACK;
        return CLS_TRAP;
    endfunction

endpackage

// File: rtl/ucf_entry_map.sv
module ucf_entry_map
    import ucf_pkg::*;
#(
    parameter int                 ENTRY_W   = 9,
    parameter logic [ENTRY_W-1:0] ENT_RM    = 9'h018,
    parameter logic [ENTRY_W-1:0] ENT_ACC   = 9'h01C,
    parameter logic [ENTRY_W-1:0] ENT_INC   = 9'h040,
    parameter logic [ENTRY_W-1:0] ENT_STACK = 9'h050,
    parameter logic [ENTRY_W-1:0] ENT_TRAP  = 9'h1FF
) (
    input  logic [OPC_W-1:0]   opcode,
    output logic [ENTRY_W-1:0] entry
);

    op_class_e cls;

    always_comb begin
        cls = classify(opcode);
        unique case (cls)
            CLS_ALU_RM:  entry = ENT_RM;
            CLS_ALU_ACC: entry = ENT_ACC;
            CLS_INCDEC:  entry = ENT_INC;
            CLS_STACK:   entry = ENT_STACK;
            default:     entry = ENT_TRAP;
        endcase
    end

endmodule

// File: rtl/ucf_load_stage.sv
module ucf_load_stage
    import ucf_pkg::*;
#(
    parameter int STEP_W  = 4,
    parameter int OPF_LSB = 3,
    parameter int OPF_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              first_strobe,
    input  logic [OPC_W-1:0]  queue_byte,
    output logic [OPC_W-1:0]  opcode,
    output logic [STEP_W-1:0] step,
    output logic [OPF_W-1:0]  opfield,
    output logic              loaded
);

    localparam logic [STEP_W-1:0] STEP_MAX = {STEP_W{1'b1}};

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [STEP_W-1:0] step;
        logic [OPF_W-1:0]  opfield;
        logic              loaded;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        if (!hold) begin
            if (first_strobe) begin
                ld_d.opcode  = queue_byte;
                ld_d.step    = '0;
                ld_d.opfield = queue_byte[OPF_LSB +: OPF_W];
                ld_d.loaded  = 1'b1;
            end else if (ld_q.loaded && ld_q.step != STEP_MAX) begin
                ld_d.step = ld_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ld_q <= '0;
        else     ld_q <= ld_d;
    end

    assign opcode  = ld_q.opcode;
    assign step    = ld_q.step;
    assign opfield = ld_q.opfield;
    assign loaded  = ld_q.loaded;

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (first_strobe && !hold) |=> (ld_q.step == '0 && ld_q.loaded &&
            ld_q.opfield == $past(queue_byte[OPF_LSB +: OPF_W])));

    assert_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (!hold && !first_strobe && ld_q.loaded && ld_q.step != STEP_MAX)
            |=> (ld_q.step == STEP_W'($past(ld_q.step) + 1'b1)));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (rst)
        (!first_strobe && ld_q.step == STEP_MAX) |=> (ld_q.step == STEP_MAX));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(ld_q.opcode) && $stable(ld_q.step) && $stable(ld_q.opfield)));

    assert_opfield_R9: assert property (@(posedge clk) disable iff (rst)
        (!first_strobe) |=> $stable(ld_q.opfield));

endmodule

// File: rtl/ucf_rom_stage.sv
module ucf_rom_stage #(
    parameter int ENTRY_W = 9,
    parameter int STEP_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [ENTRY_W-1:0] entry_in,
    input  logic [STEP_W-1:0]  step_in,
    input  logic               valid_in,
    output logic [ENTRY_W-1:0] entry,
    output logic [STEP_W-1:0]  step,
    output logic               valid
);

    typedef struct packed {
        logic [ENTRY_W-1:0] entry;
        logic [STEP_W-1:0]  step;
        logic               valid;
    } rs_t;

    rs_t rs_d, rs_q;

    always_comb begin
        rs_d = rs_q;
        if (!hold) begin
            rs_d.entry = entry_in;
            rs_d.step  = step_in;
            rs_d.valid = valid_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rs_q <= '0;
        else     rs_q <= rs_d;
    end

    assign entry = rs_q.entry;
    assign step  = rs_q.step;
    assign valid = rs_q.valid;

    assert_rom_hold_R8: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(rs_q.entry) && $stable(rs_q.step) && $stable(rs_q.valid)));

    assert_valid_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        rs_q.valid |=> rs_q.valid);

endmodule

// File: rtl/ucode_addr_front.sv
module ucode_addr_front
    import ucf_pkg::*;
#(
    parameter int                 ENTRY_W   = 9,
    parameter int                 STEP_W    = 4,
    parameter int                 OPF_LSB   = 3,
    parameter int                 OPF_W     = 3,
    parameter logic [ENTRY_W-1:0] ENT_RM    = 9'h018,
    parameter logic [ENTRY_W-1:0] ENT_ACC   = 9'h01C,
    parameter logic [ENTRY_W-1:0] ENT_INC   = 9'h040,
    parameter logic [ENTRY_W-1:0] ENT_STACK = 9'h050,
    parameter logic [ENTRY_W-1:0] ENT_TRAP  = 9'h1FF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               first_strobe,
    input  logic [OPC_W-1:0]   queue_byte,
    output logic [ENTRY_W-1:0] rom_entry,
    output logic [STEP_W-1:0]  rom_step,
    output logic               rom_valid,
    output logic [OPF_W-1:0]   alu_op
);

    logic [OPC_W-1:0]   opcode_q;
    logic [STEP_W-1:0]  step_q;
    logic               loaded_q;
    logic [ENTRY_W-1:0] entry_c;

    ucf_load_stage #(
        .STEP_W (STEP_W),
        .OPF_LSB(OPF_LSB),
        .OPF_W  (OPF_W)
    ) u_load (
        .clk         (clk),
        .rst         (rst),
        .hold        (hold),
        .first_strobe(first_strobe),
        .queue_byte  (queue_byte),
        .opcode      (opcode_q),
        .step        (step_q),
        .opfield     (alu_op),
        .loaded      (loaded_q)
    );

    ucf_entry_map #(
        .ENTRY_W  (ENTRY_W),
        .ENT_RM   (ENT_RM),
        .ENT_ACC  (ENT_ACC),
        .ENT_INC  (ENT_INC),
        .ENT_STACK(ENT_STACK),
        .ENT_TRAP (ENT_TRAP)
    ) u_map (
        .opcode(opcode_q),
        .entry (entry_c)
    );

    ucf_rom_stage #(
        .ENTRY_W(ENTRY_W),
        .STEP_W (STEP_W)
    ) u_rom (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .entry_in(entry_c),
        .step_in (step_q),
        .valid_in(loaded_q),
        .entry   (rom_entry),
        .step    (rom_step),
        .valid   (rom_valid)
    );

    // A strobe followed by a cycle without hold starts a routine at step 0.
    assert_fetch_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (first_strobe && !hold) ##1 (!hold) |=> (rom_valid && rom_step == '0));

    assert_entry_legal_R4: assert property (@(posedge clk) disable iff (rst)
        rom_valid |-> (rom_entry == ENT_RM || rom_entry == ENT_ACC ||
                       rom_entry == ENT_INC || rom_entry == ENT_STACK ||
                       rom_entry == ENT_TRAP));

    assert_b2b_R7: assert property (@(posedge clk) disable iff (rst)
        (first_strobe && !hold) ##1 (first_strobe && !hold) ##1 (!hold)
            |=> (rom_step == '0));

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (!rom_valid && !loaded_q) |-> (rom_step == '0));

endmodule

// File: tb/ucode_addr_front_bench.sv
`timescale 1ns/1ps
module ucode_addr_front_bench;

    logic       clk = 1'b0;
    logic       rst, hold, first_strobe;
    logic [7:0] queue_byte;
    logic [8:0] rom_entry;
    logic [3:0] rom_step;
    logic       rom_valid;
    logic [2:0] alu_op;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ucode_addr_front u_ucode_addr_front (
        .clk(clk), .rst(rst), .hold(hold), .first_strobe(first_strobe),
        .queue_byte(queue_byte), .rom_entry(rom_entry), .rom_step(rom_step),
        .rom_valid(rom_valid), .alu_op(alu_op)
    );

    // {opcode, expected entry, expected alu_op}
    localparam logic [19:0] VEC [14] = '{
        {8'h00, 9'h018, 3'd0}, {8'h01, 9'h018, 3'd0}, {8'h03, 9'h018, 3'd0},
        {8'h28, 9'h018, 3'd5}, {8'h3B, 9'h018, 3'd7}, {8'h04, 9'h01C, 3'd0},
        {8'h2D, 9'h01C, 3'd5}, {8'h06, 9'h1FF, 3'd0}, {8'h3F, 9'h1FF, 3'd7},
        {8'h43, 9'h040, 3'd0}, {8'h5A, 9'h050, 3'd3}, {8'h90, 9'h1FF, 3'd2},
        {8'hFF, 9'h1FF, 3'd7}, {8'h60, 9'h1FF, 3'd4}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic strobe_byte(input logic [7:0] b);
        first_strobe = 1'b1;
        queue_byte   = b;
        tick();
        first_strobe = 1'b0;
    endtask

    initial begin
        rst = 1'b1; hold = 1'b0; first_strobe = 1'b0; queue_byte = 8'h00;
        repeat (3) tick();
        chk("R1 valid", int'(rom_valid), 0);
        chk("R1 entry", int'(rom_entry), 0);
        chk("R1 step",  int'(rom_step),  0);
        chk("R1 aluop", int'(alu_op),    0);
        rst = 1'b0;
        repeat (2) tick();
        chk("R1 idle valid", int'(rom_valid), 0);

        // Table walk: load, check op field after one edge, ROM after two.
        for (int i = 0; i < 14; i++) begin
            strobe_byte(VEC[i][19:12]);
            chk("R2 aluop", int'(alu_op), int'(VEC[i][2:0]));
            tick();
            chk("R3 valid", int'(rom_valid), 1);
            chk("R3 step",  int'(rom_step),  0);
            chk("R4 entry", int'(rom_entry), int'(VEC[i][11:3]));
        end

        // Step advance and saturation.
        strobe_byte(8'h01);
        tick();
        for (int k = 1; k <= 15; k++) begin
            tick();
            chk("R5 step",  int'(rom_step),  k);
            chk("R5 entry", int'(rom_entry), 9'h018);
            chk("R9 aluop", int'(alu_op),    0);
        end
        repeat (3) tick();
        chk("R6 step", int'(rom_step), 15);

        // Hold mid-routine with a strobe presented.
        strobe_byte(8'h28);
        repeat (3) tick();
        chk("R5 step before hold", int'(rom_step), 2);
        hold = 1'b1; first_strobe = 1'b1; queue_byte = 8'h43;
        repeat (3) tick();
        chk("R8 step",  int'(rom_step),  2);
        chk("R8 entry", int'(rom_entry), 9'h018);
        chk("R8 aluop", int'(alu_op),    5);
        chk("R8 valid", int'(rom_valid), 1);
        hold = 1'b0; first_strobe = 1'b0;
        tick();
        chk("R8 resume step",  int'(rom_step),  3);
        chk("R8 resume entry", int'(rom_entry), 9'h018);

        // Back-to-back strobes.
        strobe_byte(8'h04);
        first_strobe = 1'b1; queue_byte = 8'h50;
        tick();
        first_strobe = 1'b0;
        chk("R7 aluop",        int'(alu_op),    2);
        chk("R7 first entry",  int'(rom_entry), 9'h01C);
        chk("R7 first step",   int'(rom_step),  0);
        tick();
        chk("R7 second entry", int'(rom_entry), 9'h050);
        chk("R7 second step",  int'(rom_step),  0);

        // Reset in the middle of a routine.
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 mid valid", int'(rom_valid), 0);
        chk("R1 mid entry", int'(rom_entry), 0);
        chk("R1 mid aluop", int'(alu_op),    0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule